// File: doc/BRIEF.md
# Complex Q1.15 Gain and Offset Stage

This block scales and shifts a stream of complex baseband samples. Each sample word carries a signed in-phase part and a signed quadrature part. Both parts, the gain and the offset are read as Q1.15 fractions: a code N stands for N/2^15, so the range runs from -1 to just under +1. The block multiplies each part by the gain and rescales the double-width product back to Q1.15 with rounding. It then adds the offset, which moves the signal by its fractional value and not by raw counts. Every step saturates to the Q1.15 range.

Samples enter and leave through valid/ready handshakes. The datapath is a two-stage pipeline that stalls as a whole when the consumer is not ready. Gain and offset are held in two registers loaded through a single-cycle write port. A write takes effect only for samples accepted after it, so every output sample is computed with one consistent pair of settings.

Top module: `cplx_gain_offset`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is low. After reset the gain is 0x7FFF and the offset is 0, so a sample of code N leaves as round(N*32767/32768).
- R2: A sample word carries the in-phase part in bits [31:16] and the quadrature part in bits [15:0], both in two's complement. The output uses the same packing, and the two parts are processed independently with the same gain and offset.
- R3: The product sample*gain is rescaled by 2^-15 with rounding half away from zero. With gain 0x4000, code 1 gives 1, code -1 gives -1, code 3 gives 2 and code -3 gives -2.
- R4: A rescaled product above 0x7FFF saturates to 0x7FFF. The only such case is -1 times -1 (0x8000 by 0x8000), which gives 0x7FFF.
- R5: The offset is added to the rescaled product as a signed Q1.15 value. A sum above 0x7FFF gives 0x7FFF, and a sum below 0x8000 (-1) gives 0x8000.
- R6: A sample accepted on clock edge k appears on out_data with out_valid high after edge k+1, and it is taken at edge k+2 when out_ready stays high. Back-to-back samples flow at one per cycle.
- R7: While out_valid is high and out_ready is low, out_valid stays high, out_data stays unchanged and in_ready is low. Samples are neither lost nor duplicated, and they leave in the order they were accepted.
- R8: A write with cfg_we high loads cfg_wdata into the gain when cfg_sel is 0 and into the offset when cfg_sel is 1. A sample accepted on the same edge as the write still uses the old value. Samples accepted on later edges use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | 32 | Input sample: I in [31:16], Q in [15:0] |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer accepts the output sample |
| out_data | output | 32 | Output sample, same packing as the input |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 gain, 1 offset |
| cfg_wdata | input | 16 | Q1.15 value to write |

## Verification
A register write and a sample acceptance can fall on the same clock edge. In that case the sample must still see the old setting, and the sample accepted on the next edge must see the new one. The bench provokes this by issuing random gain and offset writes on arbitrary cycles while a sample stream runs under random backpressure. A behavioural model snapshots its own setting copies at each predicted acceptance and applies the write only after the acceptance, and every output is compared against that model. Stalls can also coincide with writes, so the snapshot must survive a held pipeline. The model checks this by holding each expected value in a queue until its handshake.

// File: rtl/gof_pkg.sv
// Package: shared definitions for the complex gain/offset stage.
// Assumes: a single write port selects one of two settings registers.
package gof_pkg;
    typedef enum logic {
        CFG_GAIN   = 1'b0,
        CFG_OFFSET = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/gof_cfg_regs.sv
// Module: holds the gain and offset settings.
// Assumes: a write becomes visible on the edge after cfg_we, so a sample
// captured on the write edge still reads the old value.
module gof_cfg_regs #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [W-1:0]        cfg_wdata,
    output logic signed [W-1:0] gain,
    output logic signed [W-1:0] offs
);
    import gof_pkg::*;

    localparam logic signed [W-1:0] GAIN_RST = {1'b0, {(W-1){1'b1}}};

    logic signed [W-1:0] gain_q;
    logic signed [W-1:0] offs_q;

    // Load the selected settings register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= GAIN_RST;
            offs_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel_e'(cfg_sel) == CFG_GAIN) gain_q <= cfg_wdata;
            else                                  offs_q <= cfg_wdata;
        end
    end

    assign gain = gain_q;
    assign offs = offs_q;

    // R8: with no write strobe, neither setting moves.
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(gain_q) && $stable(offs_q)));

    // R8: a gain write lands and leaves the offset untouched.
    a_r8_gain_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> (gain_q == $past(cfg_wdata) && $stable(offs_q)));

    // R8: an offset write lands and leaves the gain untouched.
    a_r8_offs_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> (offs_q == $past(cfg_wdata) && $stable(gain_q)));
endmodule

// File: rtl/gof_pipe_ctrl.sv
// Module: valid tracking for the two-stage pipeline.
// Assumes: both stages advance together; the pipeline moves whenever the
// output stage is empty or being drained.
module gof_pipe_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic adv,
    output logic out_valid
);
    logic s1_v;
    logic s2_v;

    assign adv       = !s2_v || out_ready;
    assign in_ready  = adv;
    assign out_valid = s2_v;

    // Move valid flags one stage forward on every advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
        end else if (adv) begin
            s1_v <= in_valid;
            s2_v <= s1_v;
        end
    end

    // R6: an accepted sample occupies stage one on the next cycle.
    a_r6_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> s1_v);

    // R6: a filled stage one moves to the output on an advance.
    a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && adv) |=> out_valid);

    // R7: a refused output sample stays offered.
    a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);
endmodule

// File: rtl/gof_lane.sv
// Module: one real lane. Stage one registers the full product and a copy
// of the offset; stage two rounds, saturates, adds the offset and
// saturates again.
// Assumes: inputs and settings are signed Q1.15 codes of width W.
module gof_lane #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic signed [W-1:0] smp,
    input  logic signed [W-1:0] gain,
    input  logic signed [W-1:0] offs,
    output logic signed [W-1:0] res
);
    localparam int PW = 2 * W;
    localparam logic signed [PW:0]   BIAS_POS = (PW + 1)'(1) << (W - 2);
    localparam logic signed [PW:0]   BIAS_NEG = BIAS_POS - (PW + 1)'(1);
    localparam logic signed [W-1:0]  MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0]  MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [PW-1:0] CORNER = PW'(1) << (PW - 2);

    logic signed [PW-1:0] prod_q;
    logic signed [W-1:0]  off_q;
    logic signed [W-1:0]  res_q;
    logic signed [PW:0]   rnd_sum;
    logic signed [PW:0]   scaled;
    logic signed [W-1:0]  scl;
    logic signed [W:0]    osum;
    logic signed [W-1:0]  fin;

    // Stage one: capture the product and the offset in force at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            off_q  <= '0;
        end else if (adv) begin
            prod_q <= smp * gain;
            off_q  <= offs;
        end
    end

    // Round half away from zero, rescale by 2^-(W-1), then clamp.
    always_comb begin
        rnd_sum = {prod_q[PW-1], prod_q} + (prod_q[PW-1] ? BIAS_NEG : BIAS_POS);
        scaled  = rnd_sum >>> (W - 1);
        if ((scaled[PW:W-1] == '0) || (scaled[PW:W-1] == '1))
            scl = scaled[W-1:0];
        else
            scl = scaled[PW] ? MINV : MAXV;
    end

    // Add the offset one bit wider, then clamp to the Q1.15 range.
    always_comb begin
        osum = {scl[W-1], scl} + {off_q[W-1], off_q};
        if (osum[W] != osum[W-1])
            fin = osum[W] ? MINV : MAXV;
        else
            fin = osum[W-1:0];
    end

    // Stage two: register the lane result.
    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else if (adv) res_q <= fin;
    end

    assign res = res_q;

    // R4: minus one times minus one clamps to the largest code.
    a_r4_corner_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && prod_q == CORNER && off_q == '0) |=> res_q == MAXV);

    // R5: with zero offset, the result is the rescaled product unchanged.
    a_r5_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && off_q == '0) |=> res_q == $past(scl));
endmodule

// File: rtl/cplx_gain_offset.sv
// Module: complex Q1.15 gain and offset stage, top level.
// Assumes: sample word packs I in the upper half and Q in the lower half;
// two-cycle latency, whole pipeline stalls on output backpressure.
module cplx_gain_offset #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [2*W-1:0] in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [2*W-1:0] out_data,
    input  logic           cfg_we,
    input  logic           cfg_sel,
    input  logic [W-1:0]   cfg_wdata
);
    localparam int LANES = 2;

    logic                adv;
    logic signed [W-1:0] gain;
    logic signed [W-1:0] offs;

    gof_cfg_regs #(.W(W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .gain      (gain),
        .offs      (offs)
    );

    gof_pipe_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .adv       (adv),
        .out_valid (out_valid)
    );

    // Lane 0 carries Q (low half), lane 1 carries I (high half).
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [W-1:0] lane_res;
        gof_lane #(.W(W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .smp   (in_data[k*W +: W]),
            .gain  (gain),
            .offs  (offs),
            .res   (lane_res)
        );
        assign out_data[k*W +: W] = lane_res;
    end

    // R7: a refused output word does not change.
    a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data));

    // R7: no new sample is taken while the output is held.
    a_r7_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/cplx_gain_offset_test.sv
module cplx_gain_offset_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag = "R1";
    bit lat_on = 0;
    bit bp_mode = 0;
    bit done = 0;

    int m_gain = 32767;
    int m_offs = 0;
    logic [31:0] exp_q[$];
    int acc_q[$];
    bit prev_hold = 0;
    logic [31:0] prev_data = '0;

    always #5 clk = ~clk;

    cplx_gain_offset uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata)
    );

    function automatic int clamp(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Behavioural lane model: real-valued rounding on magnitudes.
    function automatic logic [15:0] lane_model(logic [15:0] s, int g, int o);
        int p, r;
        p = int'($signed(s)) * g;
        if (p >= 0) r = (p + 16384) / 32768;
        else        r = -((-p + 16384) / 32768);
        r = clamp(r);
        r = clamp(r + o);
        return r[15:0];
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: runs between negedge and posedge, predicts the coming edge.
    always begin
        @(negedge clk);
        #3;
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog got %0d expected %0d", cyc, 150000);
            finish_run();
        end
        if (!rst_n) begin
            check("R1", {31'd0, out_valid}, 32'd0);
            prev_hold = 0;
        end else begin
            if (prev_hold) begin
                check("R7", {31'd0, out_valid}, 32'd1);
                check("R7", out_data, prev_data);
            end
            if (out_valid && !out_ready)
                check("R7", {31'd0, in_ready}, 32'd0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R7", out_data, 32'hxxxx_xxxx);
                end else begin
                    logic [31:0] e;
                    int a;
                    e = exp_q.pop_front();
                    a = acc_q.pop_front();
                    check(tag, out_data, e);
                    if (lat_on) check("R6", cyc - a, 2);
                end
            end
            if (in_valid && in_ready) begin
                exp_q.push_back({lane_model(in_data[31:16], m_gain, m_offs),
                                 lane_model(in_data[15:0],  m_gain, m_offs)});
                acc_q.push_back(cyc);
            end
            if (cfg_we) begin
                if (cfg_sel) m_offs = int'($signed(cfg_wdata));
                else         m_gain = int'($signed(cfg_wdata));
            end
            prev_hold = out_valid && !out_ready;
            prev_data = out_data;
        end
    end

    // Output ready driver.
    always begin
        @(negedge clk);
        out_ready = bp_mode ? 1'($urandom % 2) : 1'b1;
    end

    task automatic send(logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #4;
        while (!in_ready) begin
            @(negedge clk);
            #4;
        end
        @(posedge clk);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit sel, logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: first cycle after reset checked by monitor via out_valid
        @(negedge clk); #3;
        check("R1", {31'd0, out_valid}, 32'd0);

        tag = "R1"; lat_on = 1;
        send(32'h4000_C000);
        send(32'h7FFF_0001);
        idle(4);

        tag = "R2";
        send(32'h1234_EDCC);
        send(32'h7FFF_8000);
        send(32'h0000_5A5A);
        idle(4);

        wr(0, 16'h4000);
        tag = "R3";
        send(32'h0001_FFFF);
        send(32'h0003_FFFD);
        send(32'h0002_FFFE);
        idle(4);

        wr(0, 16'h8000);
        tag = "R4";
        send(32'h8000_7FFF);
        send(32'h8000_8000);
        idle(4);

        wr(0, 16'h7FFF);
        wr(1, 16'h0CCD);
        tag = "R5";
        send(32'h0000_0000);
        idle(3);
        wr(1, 16'h2000);
        send(32'h7000_9000);
        idle(3);
        wr(1, 16'h8000);
        send(32'h9000_4000);
        idle(4);

        wr(1, 16'h0000);
        tag = "R6";
        for (int k = 0; k < 20; k++) send($urandom);
        idle(4);

        tag = "R7"; lat_on = 0; bp_mode = 1;
        for (int k = 0; k < 200; k++) begin
            send($urandom);
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(10);

        tag = "R8";
        fork
            begin
                for (int k = 0; k < 120; k++) send($urandom);
                idle(1);
            end
            begin
                for (int k = 0; k < 40; k++) begin
                    wr(1'($urandom % 2), 16'($urandom));
                    repeat ($urandom % 3) @(negedge clk);
                end
            end
        join
        bp_mode = 0;
        idle(10);
        check("R7", exp_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule